// File: doc/BRIEF.md
# Greedy-Then-Oldest Warp Issue Arbiter

This block picks which warp may issue next in a multi-warp core. Each cycle it receives a per-warp request mask and a suppress mask, where a set suppress bit marks a warp whose target functional unit cannot take more work. A warp is eligible when it requests and is not suppressed. Among the eligible warps the block first prefers the warp that was last accepted for issue, so a running warp keeps the pipeline until it stalls. Only when that warp drops out does the block fall back to the eligible warp that has waited longest.

Age is kept as a strict relative order over all warps. An accepted issue moves the granted warp to the youngest position and leaves the relative order of the others unchanged. Suppression does not touch this order, so a suppressed warp keeps getting older while others issue. It regains priority as soon as its unit drains. The grant is purely combinational from the current state and the two masks. A separate accept strobe confirms that the grant was taken, and only an accepted issue changes the age order or the greedy pointer.

Top module: `warp_issue_gto`

## Requirements
- R1: A warp is eligible when its `req` bit is 1 and its `suppress` bit is 0. `grant_valid` is 1 exactly when at least one warp is eligible. `grant` never has a bit set for a warp that is not eligible, and it is all zero when no warp is eligible.
- R2: `grant` has at most one bit set. When `grant_valid` is 1, `grant_idx` is the position of that bit. When `grant_valid` is 0, `grant_idx` is 0.
- R3: After reset the age order follows the warp index, with warp 0 the oldest, and there is no greedy warp.
- R4: If the warp recorded by the most recent accepted issue is eligible, it is granted, whatever its age.
- R5: If the recorded warp is not eligible, or none has been recorded yet, the oldest eligible warp is granted.
- R6: An accepted issue (`accept` = 1 while `grant_valid` = 1) makes the granted warp the youngest. The other warps keep their relative order. The same issue records the granted warp as the greedy warp.
- R7: A suppressed warp is never granted, but it keeps its place in the age order. After its suppress bit clears, it wins over every warp that issued while it was suppressed, unless the greedy warp is eligible.
- R8: `accept` while `grant_valid` is 0 has no effect on the age order or on the greedy warp.
- R9: A grant that is not accepted changes neither the age order nor the greedy warp.
- R10: `grant`, `grant_idx` and `grant_valid` follow a change of `req` or `suppress` within the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_WARPS | Per-warp issue request |
| suppress | input | NUM_WARPS | Per-warp exclusion, 1 = target unit full |
| accept | input | 1 | The current grant was taken this cycle |
| grant | output | NUM_WARPS | One-hot grant, or zero |
| grant_idx | output | IDX_W | Index of the granted warp, 0 when none |
| grant_valid | output | 1 | At least one warp is eligible |

## Verification
The bench first holds the reset state, with no accept. It sweeps every pairing of request and suppress masks for four warps, which must reduce to the lowest-indexed eligible warp. Any drift from that rule shows a wrong initial order or a suppress mask that leaks into the grant. Short directed sequences then separate greedy retention from the age fallback. They also check suppressed aging against plain exclusion, and accepted issues against ignored ones (an accept with no valid grant, and grants that are never accepted). A long pseudo-random run mixes all masks and accept patterns against a reference order list. That run exposes any update that reorders the warps that were not granted.

// File: rtl/gto_pkg.sv
package gto_pkg;
   // Upper bound kept so the pairwise age store stays small.
   localparam int MAX_WARPS = 64;

   // Which rule produced the current grant.
   typedef enum logic {
      SRC_OLDEST = 1'b0,
      SRC_GREEDY = 1'b1
   } pick_src_e;

   // Number of stored ordering bits for n warps (one per unordered pair).
   function automatic int pair_count(input int n);
      return (n * (n - 1)) / 2;
   endfunction

   // Flat slot of the pair (a, b) with a < b in the triangular store.
   function automatic int pair_slot(input int n, input int a, input int b);
      return a * n - (a * (a + 1)) / 2 + (b - a - 1);
   endfunction
endpackage

// File: rtl/gto_age_matrix.sv
// Pairwise relative age. One stored bit per unordered pair (a<b):
// bit = 1 means warp a is older than warp b.
// older_o[i*N+j] = 1 means warp i is not younger than warp j (diagonal = 1).
module gto_age_matrix import gto_pkg::*; #(
   parameter int N = 8,
   localparam int PAIRS = (N * (N - 1)) / 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           upd_vld,
   input  logic [N-1:0]   upd_oh,
   output logic [N*N-1:0] older_o
);
   logic [PAIRS-1:0] pair_q;

   for (genvar a = 0; a < N; a++) begin : g_a
      for (genvar b = a + 1; b < N; b++) begin : g_b
         localparam int SLOT = pair_slot(N, a, b);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pair_q[SLOT] <= 1'b1;               // lower index is older
            end else if (upd_vld && (upd_oh[a] || upd_oh[b])) begin
               pair_q[SLOT] <= upd_oh[b];          // the issued warp turns youngest
            end
         end
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         if (i == j) begin : g_diag
            assign older_o[i*N+j] = 1'b1;
         end else if (i < j) begin : g_up
            assign older_o[i*N+j] = pair_q[pair_slot(N, i, j)];
         end else begin : g_lo
            assign older_o[i*N+j] = ~pair_q[pair_slot(N, j, i)];
         end
      end
   end
endmodule

// File: rtl/gto_oldest_pick.sv
// Selects the single eligible warp that is older than every other eligible one.
module gto_oldest_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0]   elig,
   input  logic [N*N-1:0] older,
   output logic [N-1:0]   oldest_oh
);
   for (genvar i = 0; i < N; i++) begin : g_cand
      logic beats_all;
      always_comb begin
         beats_all = 1'b1;
         for (int j = 0; j < N; j++) begin
            beats_all &= (~elig[j]) | older[i*N+j];
         end
      end
      assign oldest_oh[i] = elig[i] & beats_all;
   end
endmodule

// File: rtl/gto_greedy_keep.sv
// Remembers the warp of the last accepted issue (one-hot, zero after reset).
module gto_greedy_keep #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take,
   input  logic [N-1:0] grant_oh,
   output logic [N-1:0] last_oh
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_oh <= '0;
      end else if (take) begin
         last_oh <= grant_oh;
      end
   end
endmodule

// File: rtl/gto_oh_encode.sv
// One-hot (or zero) to binary index; zero input gives index 0.
module gto_oh_encode #(
   parameter int N = 8,
   parameter int W = 3
) (
   input  logic [N-1:0] oh,
   output logic [W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (oh[i]) idx |= W'(i);
      end
   end
endmodule

// File: rtl/warp_issue_gto.sv
module warp_issue_gto import gto_pkg::*; #(
   parameter int NUM_WARPS = 8,
   localparam int IDX_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] req,
   input  logic [NUM_WARPS-1:0] suppress,
   input  logic                 accept,
   output logic [NUM_WARPS-1:0] grant,
   output logic [IDX_W-1:0]     grant_idx,
   output logic                 grant_valid
);
   if (NUM_WARPS < 2 || NUM_WARPS > MAX_WARPS) begin : g_bad_cfg
      $error("warp_issue_gto: NUM_WARPS must lie in 2..MAX_WARPS");
   end

   logic [NUM_WARPS-1:0]           elig;
   logic [NUM_WARPS-1:0]           last_oh;
   logic [NUM_WARPS-1:0]           keep_oh;
   logic [NUM_WARPS-1:0]           oldest_oh;
   logic [NUM_WARPS*NUM_WARPS-1:0] older;
   logic                           take;
   pick_src_e                      src;

   assign elig        = req & ~suppress;
   assign grant_valid = |elig;
   assign take        = accept & grant_valid;
   assign keep_oh     = last_oh & elig;
   assign src         = (|keep_oh) ? SRC_GREEDY : SRC_OLDEST;
   assign grant       = (src == SRC_GREEDY) ? keep_oh : oldest_oh;

   gto_age_matrix #(.N(NUM_WARPS)) u_age (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd_vld (take),
      .upd_oh  (grant),
      .older_o (older)
   );

   gto_oldest_pick #(.N(NUM_WARPS)) u_pick (
      .elig      (elig),
      .older     (older),
      .oldest_oh (oldest_oh)
   );

   gto_greedy_keep #(.N(NUM_WARPS)) u_keep (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .grant_oh (grant),
      .last_oh  (last_oh)
   );

   gto_oh_encode #(.N(NUM_WARPS), .W(IDX_W)) u_enc (
      .oh  (grant),
      .idx (grant_idx)
   );
endmodule

// File: rtl/gto_issue_chk.sv
module gto_issue_chk #(
   parameter int NUM_WARPS = 8,
   localparam int IDX_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_WARPS-1:0] req,
   input logic [NUM_WARPS-1:0] suppress,
   input logic                 accept,
   input logic [NUM_WARPS-1:0] grant,
   input logic [IDX_W-1:0]     grant_idx,
   input logic                 grant_valid
);
   // R1
   grant_in_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~(req & ~suppress)) == '0);

   // R1
   valid_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid == (|(req & ~suppress)));

   // R2
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (grant_valid == (grant != '0)));

   // R2
   idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> grant[grant_idx]);

   // R4
   greedy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && accept) |=>
         (!req[$past(grant_idx)] || suppress[$past(grant_idx)] ||
          (grant_valid && grant_idx == $past(grant_idx))));

   // R9
   no_accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(req) && $stable(suppress) && !$past(accept)) |-> $stable(grant));
endmodule

bind warp_issue_gto gto_issue_chk #(.NUM_WARPS(NUM_WARPS)) u_chk (.*);

// File: tb/test_warp_issue_gto.sv
module test_warp_issue_gto;
   localparam int NW = 4;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NW-1:0] req = '0;
   logic [NW-1:0] suppress = '0;
   logic          accept = 1'b0;
   logic [NW-1:0] grant;
   logic [IW-1:0] grant_idx;
   logic          grant_valid;

   int errors = 0;
   int checks = 0;
   int order[NW];   // reference age list, oldest first
   int last_w;      // reference greedy warp, -1 = none
   logic [31:0] lfsr = 32'hACE1_2468;

   always #2.5 clk = ~clk;   // 200 MHz

   warp_issue_gto #(.NUM_WARPS(NW)) i_warp_issue_gto (
      .clk(clk), .rst_n(rst_n), .req(req), .suppress(suppress), .accept(accept),
      .grant(grant), .grant_idx(grant_idx), .grant_valid(grant_valid)
   );

   task automatic model_reset();
      for (int k = 0; k < NW; k++) order[k] = k;
      last_w = -1;
   endtask

   // Drive, check the combinational outputs before the next edge, update model.
   task automatic step(input logic [NW-1:0] r, input logic [NW-1:0] s,
                       input logic a, input string tag);
      logic [NW-1:0] el, eg;
      logic          ev;
      int            g;
      @(negedge clk);
      req = r; suppress = s; accept = a;
      #1;
      el = r & ~s;
      ev = |el;
      g  = -1;
      if (last_w >= 0 && el[last_w]) g = last_w;
      else for (int k = NW - 1; k >= 0; k--) if (el[order[k]]) g = order[k];
      eg = ev ? (NW'(1) << g) : '0;
      checks++;
      if (grant !== eg || grant_valid !== ev || grant_idx !== (ev ? IW'(g) : IW'(0))) begin
         errors++;
         $display("FAIL %s: req=%b sup=%b grant=%b idx=%0d valid=%b expected grant=%b idx=%0d valid=%b",
                  tag, r, s, grant, grant_idx, grant_valid, eg, ev ? g : 0, ev);
      end
      if (a && ev) begin
         int p = 0;
         for (int k = 0; k < NW; k++) if (order[k] == g) p = k;
         for (int k = p; k < NW - 1; k++) order[k] = order[k+1];
         order[NW-1] = g;
         last_w = g;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R3, R1: no requests after reset
      step('0, '0, 1'b0, "R3_idle");

      // R3 R1 R2 R9: all mask pairs, no accept, order stays by index
      for (int r = 0; r < 16; r++)
         for (int s = 0; s < 16; s++)
            step(NW'(r), NW'(s), 1'b0, "R1_R3_sweep");

      // R8: accept with nothing eligible changes nothing
      step(4'b0000, 4'b0000, 1'b1, "R8_noreq");
      step(4'b0011, 4'b0011, 1'b1, "R8_allsup");
      step(4'b1111, 4'b0000, 1'b0, "R8_after");

      // R4: accepted warp 0 is kept
      step(4'b1111, 4'b0000, 1'b1, "R4_first");
      step(4'b1111, 4'b0000, 1'b1, "R4_keep");
      // R5 R6: warp 0 drops, oldest of 1..3 wins, then becomes youngest
      step(4'b1110, 4'b0000, 1'b1, "R5_fallback");
      step(4'b1101, 4'b0000, 1'b1, "R6_reorder");
      // R10: same cycle response to a mask change
      step(4'b1001, 4'b1000, 1'b0, "R10_comb");
      // R9: unaccepted grants leave state alone
      step(4'b0011, 4'b0000, 1'b0, "R9_hold1");
      step(4'b0011, 4'b0000, 1'b0, "R9_hold2");

      // R7: warp 2 suppressed while others issue, then wins on release
      rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      model_reset();
      step(4'b1011, 4'b0100, 1'b1, "R7_a");
      step(4'b1010, 4'b0100, 1'b1, "R7_b");
      step(4'b1000, 4'b0100, 1'b1, "R7_c");
      step(4'b0111, 4'b0000, 1'b0, "R7_release");
      step(4'b1111, 4'b0000, 1'b0, "R7_greedy_wins");

      // R5 R6 R4: long pseudo-random mix against the reference list
      for (int c = 0; c < 3000; c++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step(lfsr[3:0] | lfsr[7:4], lfsr[11:8] & lfsr[15:12], lfsr[17] | lfsr[18],
              "R5_R6_random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule